// File: doc/BRIEF.md
# Clocked Binary-to-Decimal Digit Converter

This block turns an unsigned binary word into four decimal digits, each as a 4-bit BCD code. It uses the shift-and-add-3 method and handles one binary bit per clock edge, so each step needs only a 4-bit compare-and-add per digit rather than a long chain of adders. A caller presents a value with a one-cycle start strobe. It then waits for the done pulse and reads the digits, which are held until the next conversion completes.

Only the low 14 bits of the input pass through the conversion, because 14 bits are enough for any value up to 9999. Every start also compares the full input word against 9999. If the value is larger, the converter raises an over-range flag and shows all nines, so a value too large for four digits is never shown wrapped. Each conversion reloads the working registers, so nothing from an earlier run can affect the result.

Top module: `bcd_stepper`

## Requirements
- R1: While reset is high and after it is released, busy, done and overRange are 0 and all four digit outputs are 0.
- R2: A start seen on a clock edge while busy is low loads binIn, and busy reads 1 after that edge.
- R3: done is high for exactly one cycle, 14 clock edges after the edge that loaded the input. busy falls on that same edge.
- R4: For inputs 0 to 9999, the digits hold the decimal value when done rises. digOnes is value mod 10, digTens the next decimal place, and so on up to digThousands. Each digit is coded as plain binary 0 to 9.
- R5: For an input above 9999, overRange is 1 and all four digits read 9 when done rises. overRange is 0 for inputs of 9999 or less.
- R6: A start seen while busy is high has no effect: the running conversion finishes on its original schedule with the value that was first loaded.
- R7: The digit outputs and overRange do not change between one done pulse and the next.
- R8: Each conversion starts from cleared working registers, so a result does not depend on the previous conversion.
- R9: No digit output ever holds a code above 9. Before each doubling step, any working digit above 4 gets 3 added to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a conversion of binIn (ignored while busy) |
| binIn | input | 16 | Unsigned binary value to convert |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| digOnes | output | 4 | BCD units digit |
| digTens | output | 4 | BCD tens digit |
| digHundreds | output | 4 | BCD hundreds digit |
| digThousands | output | 4 | BCD thousands digit |
| overRange | output | 1 | Input exceeded 9999; digits show 9999 |

## Verification
Busy must read high one cycle after the edge that takes the start strobe. Done, the digits and the flag must appear exactly 14 edges after that edge. When the driver drives a start, it records the cycle number on which done is due. The monitor samples on the falling clock edge and compares the cycle on which done actually arrives against that recorded cycle, so a result that arrives early or late counts as a failure even if its digits are correct. Between done pulses, the monitor checks on every cycle that the outputs have not moved, including while an ignored start is being applied.

// File: rtl/bcd_stepper_pkg.sv
package bcd_stepper_pkg;
  localparam int DIGITS = 4;
  localparam int DW     = 4 * DIGITS;

  typedef struct packed {
    logic load;    // take a new input, clear working state
    logic step;    // one adjust-then-shift step
    logic finish;  // this step is the last one: capture the result
  } strobeT;
endpackage

// File: rtl/bcd_stepper_ctrl.sv
module bcd_stepper_ctrl
  import bcd_stepper_pkg::*;
#(
  parameter int CONV_BITS = 14
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output logic   busy,
  output logic   done,
  output strobeT strobes
);
  localparam int CW = (CONV_BITS > 1) ? $clog2(CONV_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_BITS - 1);

  logic          busyQ;
  logic          doneQ;
  logic [CW-1:0] stepCnt;

  always_comb begin
    strobes.load   = start && !busyQ;
    strobes.step   = busyQ;
    strobes.finish = busyQ && (stepCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      stepCnt <= '0;
    end else begin
      doneQ <= strobes.finish;
      if (strobes.load) begin
        busyQ   <= 1'b1;
        stepCnt <= '0;
      end else if (busyQ) begin
        if (strobes.finish) busyQ <= 1'b0;
        else                stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

  // done is a single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);

  // done rises exactly when busy falls
  assert_done_with_idle_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(doneQ) |-> $fell(busyQ));

  // a start in mid-conversion leaves the run going
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (busyQ && start && stepCnt != LAST) |=> busyQ);

  // an accepted start makes the block busy
  assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busyQ) |=> busyQ);

  // the step counter stays within the conversion length
  assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
    stepCnt <= LAST);
endmodule

// File: rtl/bcd_stepper_dp.sv
module bcd_stepper_dp
  import bcd_stepper_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int CONV_BITS = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  strobeT          strobes,
  input  logic [IN_W-1:0] binIn,
  output logic [DW-1:0]   digitsOut,
  output logic            overRange
);
  localparam logic [IN_W-1:0] LIMIT     = IN_W'(10 ** DIGITS - 1);
  localparam logic [DW-1:0]   ALL_NINES = {DIGITS{4'd9}};

  logic [CONV_BITS-1:0] binReg;
  logic [DW-1:0]        bcdReg;
  logic [DW-1:0]        adjusted;
  logic [DW-1:0]        nextBcd;
  logic                 overPend;
  logic [DW-1:0]        outReg;
  logic                 overQ;

  // adjust each digit before the doubling shift
  for (genvar d = 0; d < DIGITS; d++) begin : gDigit
    logic [3:0] cur;
    assign cur = bcdReg[4*d +: 4];
    assign adjusted[4*d +: 4] = (cur > 4'd4) ? cur + 4'd3 : cur;

    assert_work_digit_R9: assert property (@(posedge clk) disable iff (rst)
      bcdReg[4*d +: 4] <= 4'd9);
    assert_out_digit_R4: assert property (@(posedge clk) disable iff (rst)
      outReg[4*d +: 4] <= 4'd9);
  end

  assign nextBcd = {adjusted[DW-2:0], binReg[CONV_BITS-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      binReg   <= '0;
      bcdReg   <= '0;
      overPend <= 1'b0;
      outReg   <= '0;
      overQ    <= 1'b0;
    end else begin
      if (strobes.load) begin
        binReg   <= binIn[CONV_BITS-1:0];
        bcdReg   <= '0;
        overPend <= (binIn > LIMIT);
      end else if (strobes.step) begin
        binReg <= {binReg[CONV_BITS-2:0], 1'b0};
        bcdReg <= nextBcd;
      end
      if (strobes.finish) begin
        outReg <= overPend ? ALL_NINES : nextBcd;
        overQ  <= overPend;
      end
    end
  end

  assign digitsOut = outReg;
  assign overRange = overQ;

  // the over-range flag always comes with all nines
  assert_over_nines_R5: assert property (@(posedge clk) disable iff (rst)
    overQ |-> (outReg == ALL_NINES));

  // results are held until the next capture
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(strobes.finish) |-> ($stable(outReg) && $stable(overQ)));
endmodule

// File: rtl/bcd_stepper.sv
module bcd_stepper
  import bcd_stepper_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int CONV_BITS = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [IN_W-1:0] binIn,
  output logic            busy,
  output logic            done,
  output logic [3:0]      digOnes,
  output logic [3:0]      digTens,
  output logic [3:0]      digHundreds,
  output logic [3:0]      digThousands,
  output logic            overRange
);
  strobeT        strobes;
  logic [DW-1:0] digitsOut;

  bcd_stepper_ctrl #(.CONV_BITS(CONV_BITS)) ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .done(done), .strobes(strobes)
  );

  bcd_stepper_dp #(.IN_W(IN_W), .CONV_BITS(CONV_BITS)) dp (
    .clk(clk), .rst(rst), .strobes(strobes), .binIn(binIn),
    .digitsOut(digitsOut), .overRange(overRange)
  );

  assign digOnes      = digitsOut[3:0];
  assign digTens      = digitsOut[7:4];
  assign digHundreds  = digitsOut[11:8];
  assign digThousands = digitsOut[15:12];
endmodule

// File: tb/bcd_stepper_test.sv
module bcd_stepper_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] binIn = '0;
  logic        busy, done, overRange;
  logic [3:0]  digOnes, digTens, digHundreds, digThousands;

  bcd_stepper uut (
    .clk(clk), .rst(rst), .start(start), .binIn(binIn),
    .busy(busy), .done(done),
    .digOnes(digOnes), .digTens(digTens),
    .digHundreds(digHundreds), .digThousands(digThousands),
    .overRange(overRange)
  );

  always #4 clk = ~clk;  // 125 MHz

  int cycleCnt = 0;
  always @(posedge clk) cycleCnt++;

  typedef struct {
    int    value;
    int    due;
    string tag;
  } itemT;
  itemT sbq[$];

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expDigit(input int v, input int place);
    if (v > 9999) return 9;
    return (v / (10 ** place)) % 10;
  endfunction

  // monitor: compares results against the scoreboard
  logic [15:0] holdDig;
  logic        holdOver;
  bit          haveHold = 0;
  always @(negedge clk) begin
    itemT it;
    if (!rst) begin
      if (done) begin
        if (sbq.size() == 0) begin
          chk(0, "R3", "done with nothing pending", 1, 0);
        end else begin
          it = sbq.pop_front();
          chk(cycleCnt == it.due, "R3", "done cycle", cycleCnt, it.due);
          chk(!busy, "R3", "busy at done", busy, 0);
          chk(digOnes == expDigit(it.value, 0), it.tag, "ones", digOnes, expDigit(it.value, 0));
          chk(digTens == expDigit(it.value, 1), it.tag, "tens", digTens, expDigit(it.value, 1));
          chk(digHundreds == expDigit(it.value, 2), it.tag, "hundreds", digHundreds, expDigit(it.value, 2));
          chk(digThousands == expDigit(it.value, 3), it.tag, "thousands", digThousands, expDigit(it.value, 3));
          chk(overRange == (it.value > 9999), "R5", "overRange", overRange, int'(it.value > 9999));
          chk(digOnes <= 9 && digTens <= 9 && digHundreds <= 9 && digThousands <= 9,
              "R9", "digit code above 9",
              {digThousands, digHundreds, digTens, digOnes}, 0);
        end
        holdDig  = {digThousands, digHundreds, digTens, digOnes};
        holdOver = overRange;
        haveHold = 1;
      end else if (haveHold) begin
        chk({digThousands, digHundreds, digTens, digOnes} == holdDig && overRange == holdOver,
            "R7", "outputs moved between results",
            {digThousands, digHundreds, digTens, digOnes}, holdDig);
      end
    end
  end

  // driver: starts a conversion and pushes its expected result
  task automatic convert(input int v, input string tag, input int ignoreV);
    @(negedge clk);
    while (busy || done) @(negedge clk);
    binIn = 16'(v);
    start = 1'b1;
    sbq.push_back('{v, cycleCnt + 15, tag});
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    if (ignoreV >= 0) begin
      // R6: a second start during the run must not disturb it
      repeat (4) @(negedge clk);
      binIn = 16'(ignoreV);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R6", "busy after ignored start", busy, 1);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !overRange, "R1", "flags in reset",
            {busy, done, overRange}, 0);
        chk({digThousands, digHundreds, digTens, digOnes} == 16'h0, "R1", "digits in reset",
            {digThousands, digHundreds, digTens, digOnes}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R1", "idle after reset", {busy, done}, 0);

        convert(0,     "R4", -1);
        convert(9999,  "R4", -1);
        convert(1234,  "R4", -1);
        convert(5,     "R4", -1);
        convert(10000, "R5", -1);
        convert(65535, "R5", -1);
        convert(16383, "R5", -1);
        convert(8765,  "R6", 42);
        convert(9999,  "R8", -1);
        convert(0,     "R8", -1);   // R8: cleared state after all nines
        convert(100,   "R4", -1);
        convert(9000,  "R4", -1);
        for (int v = 7; v < 10000; v += 731) convert(v, "R4", -1);
        while (sbq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        chk(0, "R3", "watchdog expired", cycleCnt, 0);
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule